// File: doc/BRIEF.md
# Watchdog Timer with Delayed Reset

This block is a watchdog for the system clock domain it sits in. While it is running, a 20-bit up counter advances on every clock. A 4-bit interval code picks one of nine power-of-two timeout lengths. When the chosen interval runs out, the block sets an interrupt flag. If resets are allowed, it also opens a grace window whose length comes from a 2-bit delay code. Software proves it is alive by pulsing the restart input. A restart clears the counter, the interrupt flag and any open grace window. If no restart arrives before the window closes, the block emits a one-clock reset pulse and records that event in a sticky flag.

A controller with four named states sequences the block. ST_IDLE holds the counter at zero while the watchdog is off. ST_RUN counts. ST_GRACE counts down the reset delay. ST_FIRE drives the reset pulse for one cycle. The transitions are as follows. IDLE→RUN happens on enable. RUN→GRACE happens on timeout when resets are allowed. GRACE→FIRE happens when the delay is used up. FIRE→RUN always follows after one cycle. Any state goes to RUN on a restart while running, and to IDLE when the watchdog is turned off. A strap input keeps the watchdog running whatever the enable input says.

Top module: `wdog_core`

## Requirements
- R1: After reset, irq_o, wdt_rst_o and rst_flag_o are all 0.
- R2: For interval code s in 0..8, the interrupt flag rises exactly 2^(4+2s) clocks after the clock edge that samples a restart. At the port, the flag becomes visible on the following cycle.
- R3: Interval codes 9 to 15 behave as code 8 (2^20 clocks), so no timeout occurs within a few thousand clocks.
- R4: The interrupt flag stays set until a restart clears it. irq_o shows the flag only while irq_en_i is 1, and setting irq_en_i later exposes a flag that is already set.
- R5: With rst_en_i at 0, a timeout never produces a reset pulse.
- R6: With rst_en_i at 1, wdt_rst_o rises a fixed number of clocks D after irq_o rises. D is 1026 for delay code 0, 130 for code 1, 18 for code 2 and 3 for code 3.
- R7: The reset pulse lasts exactly one clock.
- R8: A restart sampled in any cycle of the grace window, including the last one, cancels the reset.
- R9: rst_flag_o rises together with the reset pulse. It stays set until flag_clr_i is pulsed.
- R10: With en_i and strap_on_i both 0, nothing counts and no interrupt appears. Dropping the enable during the grace window cancels the reset. Enabling again times the interval from the enabling edge.
- R11: strap_on_i at 1 runs the watchdog even with en_i at 0.
- R12: Changing the interval code restarts the count, so the new interval is timed from the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run enable |
| strap_on_i | input | 1 | Forces the watchdog to run |
| kick_i | input | 1 | Restart strobe |
| tsel_i | input | 4 | Timeout interval code |
| dsel_i | input | 2 | Reset delay code |
| irq_en_i | input | 1 | Shows the interrupt flag on irq_o |
| rst_en_i | input | 1 | Allows the reset sequence |
| flag_clr_i | input | 1 | Clears the sticky reset flag |
| irq_o | output | 1 | Timeout interrupt |
| wdt_rst_o | output | 1 | One-cycle reset pulse |
| rst_flag_o | output | 1 | Sticky record of a watchdog reset |

## Verification
The hardest case to reach from the ports is a restart that lands in the very last cycle of the grace window. One clock later the controller would already be in ST_FIRE. The bench computes the restart time from the interval and delay codes, counting to the exact negative edge. Seeded random trials pick an interval, a delay and a cancel point anywhere in the window. Directed cases also place a restart at the final slot for every delay code.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_GRACE = 2'd2,
        ST_FIRE  = 2'd3
    } wd_state_e;

endpackage

// File: rtl/wdog_tick.sv
module wdog_tick #(
    parameter int CNT_W    = 20,
    parameter int SEL_W    = 4,
    parameter int TAP_N    = 9,
    parameter int TAP_LO   = 4,
    parameter int TAP_STEP = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             clr_i,
    input  logic [SEL_W-1:0] tsel_i,
    output logic             expire_o
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] tap_mask [TAP_N];
    logic [CNT_W-1:0] mask;
    logic [SEL_W-1:0] tsel_q;
    logic             chg;

    // one mask per interval code, widths grow by TAP_STEP bits
    for (genvar g = 0; g < TAP_N; g++) begin : g_tap
        localparam int TW = TAP_LO + TAP_STEP * g;
        assign tap_mask[g] = {CNT_W{1'b1}} >> (CNT_W - TW);
    end

    // codes past the last tap select the longest interval
    always_comb begin
        mask = tap_mask[TAP_N-1];
        for (int i = 0; i < TAP_N; i++) begin
            if (tsel_i == SEL_W'(i)) mask = tap_mask[i];
        end
    end

    assign chg = (tsel_i != tsel_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tsel_q <= '0;
            cnt    <= '0;
        end else begin
            tsel_q <= tsel_i;
            if (!run_i || clr_i || chg) cnt <= '0;
            else                        cnt <= cnt + 1'b1;
        end
    end

    assign expire_o = run_i && !chg && ((cnt & mask) == mask);

    assert_chg_clears_R12 : assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && chg) |=> (cnt == '0));

endmodule

// File: rtl/wdog_dly.sv
module wdog_dly #(
    parameter int DLY_W = 11,
    parameter int DLY0  = 1026,
    parameter int DLY1  = 130,
    parameter int DLY2  = 18,
    parameter int DLY3  = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_i,
    input  logic       clr_i,
    input  logic [1:0] dsel_i,
    output logic       zero_o
);

    localparam int DMAX = (DLY0 > DLY1) ? DLY0 : DLY1;

    logic [DLY_W-1:0] len;
    logic [DLY_W-1:0] dly;

    always_comb begin
        unique case (dsel_i)
            2'd0: len = DLY_W'(DLY0 - 1);
            2'd1: len = DLY_W'(DLY1 - 1);
            2'd2: len = DLY_W'(DLY2 - 1);
            2'd3: len = DLY_W'(DLY3 - 1);
            default: len = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             dly <= '0;
        else if (clr_i)         dly <= '0;
        else if (load_i)        dly <= len;
        else if (dly != '0)     dly <= dly - 1'b1;
    end

    assign zero_o = (dly == '0);

    assert_dly_bound_R6 : assert property (@(posedge clk) disable iff (!rst_n)
        32'(dly) <= DMAX - 1);

endmodule

// File: rtl/wdog_core.sv
module wdog_core
    import wdog_pkg::*;
#(
    parameter int CNT_W    = 20,
    parameter int SEL_W    = 4,
    parameter int TAP_N    = 9,
    parameter int TAP_LO   = 4,
    parameter int TAP_STEP = 2,
    parameter int DLY_W    = 11,
    parameter int DLY0     = 1026,
    parameter int DLY1     = 130,
    parameter int DLY2     = 18,
    parameter int DLY3     = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             strap_on_i,
    input  logic             kick_i,
    input  logic [SEL_W-1:0] tsel_i,
    input  logic [1:0]       dsel_i,
    input  logic             irq_en_i,
    input  logic             rst_en_i,
    input  logic             flag_clr_i,
    output logic             irq_o,
    output logic             wdt_rst_o,
    output logic             rst_flag_o
);

    wd_state_e state, nxt;
    logic run, expire, dly_zero, irq_flag, rflag;
    logic tick_clr, dly_load;

    assign run      = en_i || strap_on_i;
    assign tick_clr = kick_i || (state == ST_IDLE) || (state == ST_FIRE);
    assign dly_load = (state == ST_RUN) && (nxt == ST_GRACE);

    wdog_tick #(
        .CNT_W(CNT_W), .SEL_W(SEL_W), .TAP_N(TAP_N),
        .TAP_LO(TAP_LO), .TAP_STEP(TAP_STEP)
    ) u_tick (
        .clk(clk), .rst_n(rst_n), .run_i(run), .clr_i(tick_clr),
        .tsel_i(tsel_i), .expire_o(expire)
    );

    wdog_dly #(
        .DLY_W(DLY_W), .DLY0(DLY0), .DLY1(DLY1), .DLY2(DLY2), .DLY3(DLY3)
    ) u_dly (
        .clk(clk), .rst_n(rst_n), .load_i(dly_load), .clr_i(kick_i || !run),
        .dsel_i(dsel_i), .zero_o(dly_zero)
    );

    always_comb begin
        nxt = state;
        if (!run)        nxt = ST_IDLE;
        else if (kick_i) nxt = ST_RUN;
        else begin
            unique case (state)
                ST_IDLE:  nxt = ST_RUN;
                ST_RUN:   if (expire && rst_en_i) nxt = ST_GRACE;
                ST_GRACE: if (dly_zero) nxt = ST_FIRE;
                ST_FIRE:  nxt = ST_RUN;
                default:  nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_flag <= 1'b0;
            rflag    <= 1'b0;
        end else begin
            if (kick_i)      irq_flag <= 1'b0;
            else if (expire) irq_flag <= 1'b1;
            if (nxt == ST_FIRE && state != ST_FIRE) rflag <= 1'b1;
            else if (flag_clr_i)                    rflag <= 1'b0;
        end
    end

    always_comb begin
        irq_o      = irq_flag && irq_en_i;
        wdt_rst_o  = (state == ST_FIRE);
        rst_flag_o = rflag;
    end

    assert_pulse_one_R7 : assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst_o |=> !wdt_rst_o);

    assert_rst_after_irq_R6 : assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst_o |-> irq_flag);

    assert_kick_cancels_R8 : assert property (@(posedge clk) disable iff (!rst_n)
        kick_i |=> !wdt_rst_o);

    assert_flag_sticky_R9 : assert property (@(posedge clk) disable iff (!rst_n)
        (rst_flag_o && !flag_clr_i) |=> rst_flag_o);

    assert_off_quiet_R10 : assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !kick_i) |=> ($stable(irq_flag) && !wdt_rst_o));

    assert_no_grace_R5 : assert property (@(posedge clk) disable iff (!rst_n)
        (!rst_en_i && state == ST_RUN) |=> (state != ST_GRACE));

endmodule

// File: tb/wdog_core_tb_top.sv
module wdog_core_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_i = 1'b0, strap_on_i = 1'b0, kick_i = 1'b0;
    logic [3:0] tsel_i = '0;
    logic [1:0] dsel_i = '0;
    logic       irq_en_i = 1'b1, rst_en_i = 1'b0, flag_clr_i = 1'b0;
    logic       irq_o, wdt_rst_o, rst_flag_o;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    wdog_core dut_i (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .strap_on_i(strap_on_i),
        .kick_i(kick_i), .tsel_i(tsel_i), .dsel_i(dsel_i),
        .irq_en_i(irq_en_i), .rst_en_i(rst_en_i), .flag_clr_i(flag_clr_i),
        .irq_o(irq_o), .wdt_rst_o(wdt_rst_o), .rst_flag_o(rst_flag_o)
    );

    function automatic int period(input int s);
        int e;
        e = (s > 8) ? 8 : s;
        return 1 << (4 + 2 * e);
    endfunction

    function automatic int dly_len(input int d);
        case (d)
            0: return 1026;
            1: return 130;
            2: return 18;
            default: return 3;
        endcase
    endfunction

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic restart();
        kick_i = 1'b1;
        step(1);
        kick_i = 1'b0;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // watch n cycles, return how many had the reset pulse high
    task automatic count_rst(input int n, output int hits);
        hits = 0;
        for (int i = 0; i < n; i++) begin
            step(1);
            if (wdt_rst_o) hits++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int p, d, hits, seed, j;
        seed = 1234;
        void'($urandom(seed));
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        chk(irq_o == 0, "R1 irq", int'(irq_o), 0);
        chk(wdt_rst_o == 0, "R1 rst", int'(wdt_rst_o), 0);
        chk(rst_flag_o == 0, "R1 flag", int'(rst_flag_o), 0);

        // R10 off: nothing counts
        tsel_i = 4'd0;
        restart();
        step(300);
        chk(irq_o == 0, "R10 off irq", int'(irq_o), 0);
        en_i = 1'b1;
        step(16);
        chk(irq_o == 0, "R10 enable early", int'(irq_o), 0);
        step(1);
        chk(irq_o == 1, "R10 enable timed", int'(irq_o), 1);

        // R2 interval taps
        for (int s = 0; s < 5; s++) begin
            tsel_i = 4'(s);
            p = period(s);
            restart();
            step(p - 1);
            chk(irq_o == 0, $sformatf("R2 early s=%0d", s), int'(irq_o), 0);
            step(1);
            chk(irq_o == 1, $sformatf("R2 on time s=%0d", s), int'(irq_o), 1);
        end

        // R3 codes above 8
        tsel_i = 4'd9;
        restart();
        step(5000);
        chk(irq_o == 0, "R3 code 9", int'(irq_o), 0);
        tsel_i = 4'd15;
        restart();
        step(3000);
        chk(irq_o == 0, "R3 code 15", int'(irq_o), 0);

        // R12 interval change restarts the count
        tsel_i = 4'd2;
        restart();
        step(200);
        tsel_i = 4'd0;
        step(16);
        chk(irq_o == 0, "R12 no early", int'(irq_o), 0);
        step(1);
        chk(irq_o == 1, "R12 retimed", int'(irq_o), 1);

        // R4 masking and hold
        irq_en_i = 1'b0;
        restart();
        step(30);
        chk(irq_o == 0, "R4 masked", int'(irq_o), 0);
        irq_en_i = 1'b1;
        step(1);
        chk(irq_o == 1, "R4 exposed", int'(irq_o), 1);
        step(40);
        chk(irq_o == 1, "R4 held", int'(irq_o), 1);
        restart();
        chk(irq_o == 0, "R4 cleared", int'(irq_o), 0);

        // R5 no reset when disallowed
        rst_en_i = 1'b0;
        restart();
        count_rst(2000, hits);
        chk(hits == 0, "R5 no reset", hits, 0);
        chk(rst_flag_o == 0, "R5 flag", int'(rst_flag_o), 0);

        // R6 R7 R9 delay per code
        rst_en_i = 1'b1;
        tsel_i = 4'd0;
        p = period(0);
        for (int dc = 0; dc < 4; dc++) begin
            dsel_i = 2'(dc);
            d = dly_len(dc);
            restart();
            step(p);
            chk(irq_o == 1, $sformatf("R6 irq d=%0d", dc), int'(irq_o), 1);
            step(d - 1);
            chk(wdt_rst_o == 0, $sformatf("R6 early d=%0d", dc), int'(wdt_rst_o), 0);
            step(1);
            chk(wdt_rst_o == 1, $sformatf("R6 fire d=%0d", dc), int'(wdt_rst_o), 1);
            chk(rst_flag_o == 1, "R9 set", int'(rst_flag_o), 1);
            step(1);
            chk(wdt_rst_o == 0, "R7 one cycle", int'(wdt_rst_o), 0);
            step(5);
            chk(rst_flag_o == 1, "R9 sticky", int'(rst_flag_o), 1);
            flag_clr_i = 1'b1;
            step(1);
            flag_clr_i = 1'b0;
            chk(rst_flag_o == 0, "R9 cleared", int'(rst_flag_o), 0);
        end

        // R8 restart in the last grace cycle, each code
        for (int dc = 0; dc < 4; dc++) begin
            dsel_i = 2'(dc);
            d = dly_len(dc);
            restart();
            step(p);
            step(d - 1);
            restart();
            count_rst(d + 2, hits);
            chk(hits == 0, $sformatf("R8 last slot d=%0d", dc), hits, 0);
            chk(rst_flag_o == 0, "R8 flag", int'(rst_flag_o), 0);
        end

        // R10 disable during grace cancels
        dsel_i = 2'd1;
        restart();
        step(p + 10);
        en_i = 1'b0;
        count_rst(200, hits);
        chk(hits == 0, "R10 disable cancels", hits, 0);
        chk(rst_flag_o == 0, "R10 flag", int'(rst_flag_o), 0);

        // R11 strap runs with enable low
        strap_on_i = 1'b1;
        tsel_i = 4'd1;
        rst_en_i = 1'b0;
        restart();
        step(period(1) - 1);
        chk(irq_o == 0, "R11 early", int'(irq_o), 0);
        step(1);
        chk(irq_o == 1, "R11 timed", int'(irq_o), 1);
        strap_on_i = 1'b0;
        en_i = 1'b1;
        rst_en_i = 1'b1;

        // random trials: R6 R8
        for (int t = 0; t < 24; t++) begin
            int s, dc;
            bit cancel;
            s = int'($urandom % 3);
            dc = int'($urandom % 4);
            if (dc == 0) dc = 1 + int'($urandom % 3);
            cancel = 1'($urandom % 2);
            tsel_i = 4'(s);
            dsel_i = 2'(dc);
            p = period(s);
            d = dly_len(dc);
            flag_clr_i = 1'b1;
            restart();
            flag_clr_i = 1'b0;
            step(p);
            chk(irq_o == 1, "R2 random irq", int'(irq_o), 1);
            if (cancel) begin
                j = int'($urandom % d);
                step(j);
                restart();
                count_rst(d + 2, hits);
                chk(hits == 0, "R8 random cancel", hits, 0);
            end else begin
                step(d - 1);
                chk(wdt_rst_o == 0, "R6 random early", int'(wdt_rst_o), 0);
                step(1);
                chk(wdt_rst_o == 1, "R6 random fire", int'(wdt_rst_o), 1);
                chk(rst_flag_o == 1, "R9 random flag", int'(rst_flag_o), 1);
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule